// File: doc/BRIEF.md
# Mixed-Criticality Injection Budget Monitor

This block sits between a processing element and its network interface. It watches every flit offered for injection and checks each packet against the normal-mode budget of its flow. Each flow has a criticality tag (high or low), a fixed priority, a maximum packet length in flits and a minimum spacing in cycles between packet headers. All four are held in a small table written through a configuration port.

A packet that stays within its budget passes through one cycle later, with the flow's priority attached. A low-criticality packet that breaks its budget is cut off: the flit that breaks the budget and every later flit up to the tail are discarded, and a reject pulse is raised. A high-criticality packet that breaks its budget is still passed through in full. It also sets a sticky mode-change request, which tells the network to degrade service to low-criticality traffic. The request stays set until the system clears it.

Top module: `mc_budget_monitor`

## Requirements
- R1: A configuration write stores criticality, priority, maximum length and minimum header spacing for the addressed flow; the write takes effect from the next cycle. After reset every flow is low criticality with priority 0, maximum length 2^LEN_W-1 and minimum spacing 0. Right after reset all outputs are 0.
- R2: A flit that is within budget appears on the output one cycle after it is offered. It keeps its head and tail markers, flow and data, and carries the priority configured for its flow.
- R3: Flits are numbered from 1, starting at the header. Flit number k of a packet is over budget when k is greater than the flow's maximum length.
- R4: A header is over budget when fewer cycles than the flow's minimum spacing have passed since the last forwarded header of the same flow. The cycle distance between two headers offered at clock edges e1 and e2 is e2-e1. The distance saturates at 2^GAP_W-1, and it starts saturated after reset.
- R5: For a low-criticality flow, the flit that breaks the budget and all later flits up to and including the tail are not forwarded. pkt_reject pulses once per packet, one cycle after the offending flit. A header that is not forwarded does not restart the flow's spacing timer.
- R6: For a high-criticality flow, a flit that breaks the budget is still forwarded, and mode_req is set one cycle after it.
- R7: mode_req stays at 1 until mode_clr is sampled high. If a new high-criticality overrun happens in the same cycle as mode_clr, the overrun wins.
- R8: pkt_accept pulses together with every forwarded tail flit. This covers high-criticality packets that overran their budget. It never pulses together with pkt_reject.
- R9: A packet made of a single flit (head and tail together) is handled. A valid flit without a header, offered while no packet is open, is ignored.
- R10: Spacing timers are kept per flow. Traffic on one flow does not change the spacing verdict of another flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_flow | input | FLOW_W | Flow entry to write |
| cfg_hi_crit | input | 1 | 1 = high criticality |
| cfg_prio | input | PRIO_W | Fixed priority of the flow |
| cfg_max_len | input | LEN_W | Maximum flits per packet |
| cfg_min_gap | input | GAP_W | Minimum cycles between headers |
| in_valid | input | 1 | Flit offered for injection |
| in_head | input | 1 | Flit is a packet header |
| in_tail | input | 1 | Flit is a packet tail |
| in_flow | input | FLOW_W | Flow of the flit (used on headers) |
| in_data | input | DATA_W | Flit payload |
| mode_clr | input | 1 | Clears the mode-change request |
| out_valid | output | 1 | Forwarded flit valid |
| out_head | output | 1 | Forwarded header marker |
| out_tail | output | 1 | Forwarded tail marker |
| out_flow | output | FLOW_W | Flow of the forwarded flit |
| out_prio | output | PRIO_W | Priority of the forwarded flit |
| out_data | output | DATA_W | Forwarded payload |
| pkt_accept | output | 1 | Packet completed within policy |
| pkt_reject | output | 1 | Low-criticality packet rejected |
| mode_req | output | 1 | Sticky mode-change request |

## Verification
Some properties are checked by assertions on every cycle. A reject never comes with a forwarded flit, and an accept always marks a forwarded tail. No forwarded low-criticality packet grows past the length captured from the configuration port. mode_req holds until it is cleared, and it only rises after an offered flit. Other behaviour can only be shown by the bench scenarios, because an assertion would have to copy the design to express it. These are the exact spacing boundary at each gap value, the rule that a rejected header does not restart the timer, the per-flow independence of timers, and set-over-clear when the two happen in the same cycle.

// File: rtl/mcm_pkg.sv
`timescale 1ns/1ps
// Shared types for the budget monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package mcm_pkg;

    // Verdict on one offered flit.
    typedef enum logic [1:0] {
        VERD_IDLE     = 2'd0,
        VERD_PASS     = 2'd1,
        VERD_DROP     = 2'd2,
        VERD_ESCALATE = 2'd3
    } verdict_e;

endpackage

// File: rtl/mcm_flow_table.sv
`timescale 1ns/1ps
// Per-flow policy table: criticality, priority, length limit and header spacing.
// Assumes: one write port, one combinational read port; a flow is not
// rewritten while one of its packets is in flight.
module mcm_flow_table #(
    parameter int FLOWS  = 4,
    parameter int FLOW_W = 2,
    parameter int LEN_W  = 6,
    parameter int GAP_W  = 8,
    parameter int PRIO_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [FLOW_W-1:0] wr_flow,
    input  logic              wr_hi,
    input  logic [PRIO_W-1:0] wr_prio,
    input  logic [LEN_W-1:0]  wr_max_len,
    input  logic [GAP_W-1:0]  wr_min_gap,
    input  logic [FLOW_W-1:0] rd_flow,
    output logic              rd_hi,
    output logic [PRIO_W-1:0] rd_prio,
    output logic [LEN_W-1:0]  rd_max_len,
    output logic [GAP_W-1:0]  rd_min_gap
);

    logic              hi_q   [FLOWS];
    logic [PRIO_W-1:0] prio_q [FLOWS];
    logic [LEN_W-1:0]  len_q  [FLOWS];
    logic [GAP_W-1:0]  gap_q  [FLOWS];

    for (genvar f = 0; f < FLOWS; f++) begin : g_entry
        // Store or reset one flow entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_q[f]   <= 1'b0;
                prio_q[f] <= '0;
                len_q[f]  <= '1;
                gap_q[f]  <= '0;
            end else if (wr_en && wr_flow == FLOW_W'(f)) begin
                hi_q[f]   <= wr_hi;
                prio_q[f] <= wr_prio;
                len_q[f]  <= wr_max_len;
                gap_q[f]  <= wr_min_gap;
            end
        end
    end

    // Read the selected entry.
    always_comb begin
        rd_hi      = hi_q[rd_flow];
        rd_prio    = prio_q[rd_flow];
        rd_max_len = len_q[rd_flow];
        rd_min_gap = gap_q[rd_flow];
    end

endmodule

// File: rtl/mcm_gap_timers.sv
`timescale 1ns/1ps
// One saturating cycle timer per flow, measuring time since the flow's last
// forwarded header. A restart loads 1, so the value read at a later edge
// equals the edge distance.
// Assumes: at most one restart per cycle.
module mcm_gap_timers #(
    parameter int FLOWS  = 4,
    parameter int FLOW_W = 2,
    parameter int GAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [FLOW_W-1:0] restart_flow,
    input  logic [FLOW_W-1:0] rd_flow,
    output logic [GAP_W-1:0]  rd_elapsed
);

    localparam logic [GAP_W-1:0] SAT = '1;

    logic [GAP_W-1:0] tmr_q [FLOWS];

    for (genvar f = 0; f < FLOWS; f++) begin : g_tmr
        // Restart on a forwarded header, otherwise count up to saturation.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tmr_q[f] <= SAT;
            end else if (restart && restart_flow == FLOW_W'(f)) begin
                tmr_q[f] <= GAP_W'(1);
            end else if (tmr_q[f] != SAT) begin
                tmr_q[f] <= tmr_q[f] + GAP_W'(1);
            end
        end
    end

    // Read the selected timer.
    assign rd_elapsed = tmr_q[rd_flow];

endmodule

// File: rtl/mcm_packet_policer.sv
`timescale 1ns/1ps
// Packet tracker and budget decision. It counts flits of the open packet,
// judges each flit against the flow policy, and registers the forwarded flit,
// the per-packet verdict pulses and the sticky mode-change request.
// Assumes: packets on the injection port are not interleaved; a header
// always opens a new packet.
module mcm_packet_policer
    import mcm_pkg::*;
#(
    parameter int FLOW_W = 2,
    parameter int LEN_W  = 6,
    parameter int GAP_W  = 8,
    parameter int PRIO_W = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_head,
    input  logic              in_tail,
    input  logic [FLOW_W-1:0] in_flow,
    input  logic [DATA_W-1:0] in_data,
    input  logic              mode_clr,
    output logic [FLOW_W-1:0] sel_flow,
    input  logic              pol_hi,
    input  logic [PRIO_W-1:0] pol_prio,
    input  logic [LEN_W-1:0]  pol_max_len,
    input  logic [GAP_W-1:0]  pol_min_gap,
    input  logic [GAP_W-1:0]  elapsed,
    output logic              tmr_restart,
    output logic              out_valid,
    output logic              out_head,
    output logic              out_tail,
    output logic [FLOW_W-1:0] out_flow,
    output logic [PRIO_W-1:0] out_prio,
    output logic [DATA_W-1:0] out_data,
    output logic              pkt_accept,
    output logic              pkt_reject,
    output logic              mode_req
);

    localparam int CNT_W = LEN_W + 1;
    localparam logic [CNT_W-1:0] CNT_SAT = '1;

    logic              active_q;
    logic              drop_q;
    logic [FLOW_W-1:0] cur_q;
    logic [CNT_W-1:0]  cnt_q;

    logic              take;
    logic              cont_drop;
    logic [CNT_W-1:0]  cnt_now;
    logic              len_bad;
    logic              rate_bad;
    logic              over;
    logic              new_reject;
    logic              mode_set;
    logic              fwd;
    verdict_e          verdict;

    // Select the flow whose policy applies to the offered flit.
    assign sel_flow = in_head ? in_flow : cur_q;

    // Number the offered flit and test both budget limits.
    always_comb begin
        take      = in_valid && (in_head || active_q);
        cont_drop = active_q && drop_q && !in_head;
        if (in_head)
            cnt_now = CNT_W'(1);
        else if (cnt_q == CNT_SAT)
            cnt_now = cnt_q;
        else
            cnt_now = cnt_q + CNT_W'(1);
        len_bad  = cnt_now > {1'b0, pol_max_len};
        rate_bad = in_head && (elapsed < pol_min_gap);
        over     = len_bad || rate_bad;
    end

    // Turn the checks into a verdict by criticality.
    always_comb begin
        if (!take)
            verdict = VERD_IDLE;
        else if (cont_drop)
            verdict = VERD_DROP;
        else if (over)
            verdict = pol_hi ? VERD_ESCALATE : VERD_DROP;
        else
            verdict = VERD_PASS;
        fwd         = (verdict == VERD_PASS) || (verdict == VERD_ESCALATE);
        new_reject  = take && !cont_drop && (verdict == VERD_DROP);
        mode_set    = (verdict == VERD_ESCALATE);
        tmr_restart = fwd && in_head;
    end

    // Track the open packet, its flit count and whether it is being discarded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            drop_q   <= 1'b0;
            cur_q    <= '0;
            cnt_q    <= '0;
        end else if (take) begin
            active_q <= !in_tail;
            drop_q   <= cont_drop || new_reject;
            cur_q    <= sel_flow;
            cnt_q    <= cnt_now;
        end
    end

    // Register the forwarded flit and the packet verdict pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_head   <= 1'b0;
            out_tail   <= 1'b0;
            out_flow   <= '0;
            out_prio   <= '0;
            out_data   <= '0;
            pkt_accept <= 1'b0;
            pkt_reject <= 1'b0;
        end else begin
            out_valid  <= fwd;
            out_head   <= fwd && in_head;
            out_tail   <= fwd && in_tail;
            out_flow   <= sel_flow;
            out_prio   <= pol_prio;
            out_data   <= in_data;
            pkt_accept <= fwd && in_tail;
            pkt_reject <= new_reject;
        end
    end

    // Hold the mode-change request; a new escalation beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_req <= 1'b0;
        else if (mode_set)
            mode_req <= 1'b1;
        else if (mode_clr)
            mode_req <= 1'b0;
    end

endmodule

// File: rtl/mc_budget_monitor.sv
`timescale 1ns/1ps
// Top of the injection budget monitor: policy table, per-flow spacing timers
// and the packet policer.
// Assumes: a single injection port with non-interleaved packets.
module mc_budget_monitor #(
    parameter int FLOWS  = 4,
    parameter int LEN_W  = 6,
    parameter int GAP_W  = 8,
    parameter int PRIO_W = 3,
    parameter int DATA_W = 16,
    localparam int FLOW_W = (FLOWS > 1) ? $clog2(FLOWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [FLOW_W-1:0] cfg_flow,
    input  logic              cfg_hi_crit,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic [LEN_W-1:0]  cfg_max_len,
    input  logic [GAP_W-1:0]  cfg_min_gap,
    input  logic              in_valid,
    input  logic              in_head,
    input  logic              in_tail,
    input  logic [FLOW_W-1:0] in_flow,
    input  logic [DATA_W-1:0] in_data,
    input  logic              mode_clr,
    output logic              out_valid,
    output logic              out_head,
    output logic              out_tail,
    output logic [FLOW_W-1:0] out_flow,
    output logic [PRIO_W-1:0] out_prio,
    output logic [DATA_W-1:0] out_data,
    output logic              pkt_accept,
    output logic              pkt_reject,
    output logic              mode_req
);

    logic [FLOW_W-1:0] sel_flow;
    logic              pol_hi;
    logic [PRIO_W-1:0] pol_prio;
    logic [LEN_W-1:0]  pol_max_len;
    logic [GAP_W-1:0]  pol_min_gap;
    logic [GAP_W-1:0]  elapsed;
    logic              tmr_restart;

    mcm_flow_table #(
        .FLOWS(FLOWS), .FLOW_W(FLOW_W), .LEN_W(LEN_W),
        .GAP_W(GAP_W), .PRIO_W(PRIO_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_flow(cfg_flow), .wr_hi(cfg_hi_crit),
        .wr_prio(cfg_prio), .wr_max_len(cfg_max_len), .wr_min_gap(cfg_min_gap),
        .rd_flow(sel_flow), .rd_hi(pol_hi), .rd_prio(pol_prio),
        .rd_max_len(pol_max_len), .rd_min_gap(pol_min_gap)
    );

    mcm_gap_timers #(
        .FLOWS(FLOWS), .FLOW_W(FLOW_W), .GAP_W(GAP_W)
    ) u_timers (
        .clk(clk), .rst_n(rst_n),
        .restart(tmr_restart), .restart_flow(sel_flow),
        .rd_flow(sel_flow), .rd_elapsed(elapsed)
    );

    mcm_packet_policer #(
        .FLOW_W(FLOW_W), .LEN_W(LEN_W), .GAP_W(GAP_W),
        .PRIO_W(PRIO_W), .DATA_W(DATA_W)
    ) u_policer (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_head(in_head), .in_tail(in_tail),
        .in_flow(in_flow), .in_data(in_data), .mode_clr(mode_clr),
        .sel_flow(sel_flow), .pol_hi(pol_hi), .pol_prio(pol_prio),
        .pol_max_len(pol_max_len), .pol_min_gap(pol_min_gap),
        .elapsed(elapsed), .tmr_restart(tmr_restart),
        .out_valid(out_valid), .out_head(out_head), .out_tail(out_tail),
        .out_flow(out_flow), .out_prio(out_prio), .out_data(out_data),
        .pkt_accept(pkt_accept), .pkt_reject(pkt_reject), .mode_req(mode_req)
    );

endmodule

// File: rtl/mcm_checker.sv
`timescale 1ns/1ps
// Port-level protocol checks for the budget monitor, bound to the top.
// Assumes: flows are not reconfigured while their packets are in flight.
module mcm_checker #(
    parameter int FLOWS  = 4,
    parameter int FLOW_W = 2,
    parameter int LEN_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [FLOW_W-1:0] cfg_flow,
    input logic              cfg_hi_crit,
    input logic [LEN_W-1:0]  cfg_max_len,
    input logic              in_valid,
    input logic              mode_clr,
    input logic              out_valid,
    input logic              out_head,
    input logic              out_tail,
    input logic [FLOW_W-1:0] out_flow,
    input logic              pkt_accept,
    input logic              pkt_reject,
    input logic              mode_req
);

    logic [LEN_W-1:0] sh_max [FLOWS];
    logic             sh_hi  [FLOWS];
    logic [LEN_W:0]   oc_q;
    logic [LEN_W:0]   oc_now;

    // Shadow of the length limit and criticality, taken from the config port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int f = 0; f < FLOWS; f++) begin
                sh_max[f] <= '1;
                sh_hi[f]  <= 1'b0;
            end
        end else if (cfg_we) begin
            sh_max[cfg_flow] <= cfg_max_len;
            sh_hi[cfg_flow]  <= cfg_hi_crit;
        end
    end

    // Position of the forwarded flit within its outgoing packet.
    assign oc_now = out_head ? (LEN_W+1)'(1) : oc_q + (LEN_W+1)'(1);

    // Count forwarded flits of the current outgoing packet.
    always_ff @(posedge clk) begin
        if (!rst_n)
            oc_q <= '0;
        else if (out_valid)
            oc_q <= oc_now;
    end

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !sh_hi[out_flow] |-> oc_now <= {1'b0, sh_max[out_flow]}); // R3
    AST_REJECT_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_reject |-> !out_valid); // R5
    AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_accept && pkt_reject)); // R8
    AST_ACCEPT_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_accept |-> out_valid && out_tail); // R8
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mode_req && !mode_clr |=> mode_req); // R7
    AST_MODE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_req) |-> $past(in_valid)); // R6
    AST_FWD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R2

endmodule

bind mc_budget_monitor mcm_checker #(
    .FLOWS(FLOWS), .FLOW_W(FLOW_W), .LEN_W(LEN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_flow(cfg_flow),
    .cfg_hi_crit(cfg_hi_crit), .cfg_max_len(cfg_max_len),
    .in_valid(in_valid), .mode_clr(mode_clr), .out_valid(out_valid),
    .out_head(out_head), .out_tail(out_tail), .out_flow(out_flow),
    .pkt_accept(pkt_accept), .pkt_reject(pkt_reject), .mode_req(mode_req)
);

// File: tb/tb_mc_budget_monitor.sv
`timescale 1ns/1ps
module tb_mc_budget_monitor;

    localparam int FLOWS = 4, LEN_W = 6, GAP_W = 8, PRIO_W = 3, DATA_W = 16;
    localparam int FLOW_W = 2;
    localparam int SAT = 255;

    logic clk = 0, rst_n = 0;
    logic cfg_we = 0, cfg_hi_crit = 0;
    logic [FLOW_W-1:0] cfg_flow = 0;
    logic [PRIO_W-1:0] cfg_prio = 0;
    logic [LEN_W-1:0]  cfg_max_len = 0;
    logic [GAP_W-1:0]  cfg_min_gap = 0;
    logic in_valid = 0, in_head = 0, in_tail = 0, mode_clr = 0;
    logic [FLOW_W-1:0] in_flow = 0;
    logic [DATA_W-1:0] in_data = 0;
    logic out_valid, out_head, out_tail, pkt_accept, pkt_reject, mode_req;
    logic [FLOW_W-1:0] out_flow;
    logic [PRIO_W-1:0] out_prio;
    logic [DATA_W-1:0] out_data;

    mc_budget_monitor #(.FLOWS(FLOWS), .LEN_W(LEN_W), .GAP_W(GAP_W),
        .PRIO_W(PRIO_W), .DATA_W(DATA_W)) dut (.*);

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, errors = 0;
    int m_max[FLOWS], m_gap[FLOWS], m_prio[FLOWS], hdr_edge[FLOWS];
    bit m_hi[FLOWS];
    bit exp_mode = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic cfg(input int f, input bit hi, input int prio, input int mx, input int gap);
        cfg_we = 1; cfg_flow = FLOW_W'(f); cfg_hi_crit = hi;
        cfg_prio = PRIO_W'(prio); cfg_max_len = LEN_W'(mx); cfg_min_gap = GAP_W'(gap);
        @(posedge clk); @(negedge clk);
        cfg_we = 0;
        m_hi[f] = hi; m_prio[f] = prio; m_max[f] = mx; m_gap[f] = gap;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    // Drives one packet and checks each flit against the policy model.
    task automatic send(input int f, input int len, input int clr_k, input string req);
        bit dropping = 0;
        for (int k = 1; k <= len; k++) begin
            int d;
            bit over, fwd, newrej;
            in_valid = 1; in_head = (k == 1); in_tail = (k == len);
            in_flow = FLOW_W'(f); in_data = DATA_W'((f << 8) | k);
            mode_clr = (k == clr_k);
            @(posedge clk); @(negedge clk);
            d = (hdr_edge[f] < 0) ? SAT : cyc - hdr_edge[f];
            if (d > SAT) d = SAT;
            over = ((k == 1) && (d < m_gap[f])) || (k > m_max[f]);
            newrej = 0;
            if (m_hi[f]) fwd = 1;
            else begin
                newrej = over && !dropping;
                dropping = dropping || over;
                fwd = !dropping;
            end
            if (m_hi[f] && over) exp_mode = 1;
            else if (k == clr_k) exp_mode = 0;
            if (fwd && k == 1) hdr_edge[f] = cyc;
            chk(out_valid == fwd, req, out_valid, fwd);
            if (fwd) begin
                chk(out_head == (k == 1) && out_tail == (k == len) && out_flow == f,
                    "R2 markers", {out_head, out_tail}, {k == 1, k == len});
                chk(out_data == DATA_W'((f << 8) | k), "R2 data", out_data, (f << 8) | k);
                chk(out_prio == m_prio[f], "R2 prio", out_prio, m_prio[f]);
            end
            chk(pkt_reject == newrej, "R5 reject", pkt_reject, newrej);
            chk(pkt_accept == (fwd && k == len), "R8 accept", pkt_accept, fwd && k == len);
            chk(mode_req == exp_mode, "R7 mode", mode_req, exp_mode);
        end
        in_valid = 0; in_head = 0; in_tail = 0; mode_clr = 0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int f = 0; f < FLOWS; f++) begin
            m_max[f] = 63; m_gap[f] = 0; m_prio[f] = 0; m_hi[f] = 0; hdr_edge[f] = -1;
        end
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        // R1: outputs quiet after reset
        chk(!out_valid && !pkt_accept && !pkt_reject && !mode_req, "R1 reset", out_valid, 0);
        // R1: reset defaults admit long back-to-back packets on an unconfigured flow
        send(3, 12, 0, "R1 defaults");
        send(3, 1, 0, "R1 defaults");
        cfg(0, 0, 5, 4, 10);
        cfg(1, 1, 2, 3, 8);
        cfg(2, 0, 6, 1, 0);
        // R3: length sweep across the limit of a low flow
        for (int len = 1; len <= 6; len++) begin
            send(0, len, 0, "R3 length");
            idle(12);
        end
        // R4/R5: spacing sweep; rejected headers keep the old timer
        for (int gap = 0; gap <= 11; gap++) begin
            idle(12);
            send(0, 1, 0, "R4 spacing");
            idle(gap);
            send(0, 1, 0, "R4 spacing");
            send(0, 2, 0, "R5 no restart");
        end
        // R9: single-flit flow and stray flits
        idle(3);
        send(2, 1, 0, "R9 single");
        send(2, 2, 0, "R9 single");
        in_valid = 1; in_head = 0; in_tail = 1;
        @(posedge clk); @(negedge clk);
        in_valid = 0; in_tail = 0;
        chk(!out_valid && !pkt_accept, "R9 stray", out_valid, 0);
        // R10: interleaved flows keep separate timers
        for (int i = 0; i < 4; i++) begin
            send(0, 2, 0, "R10 flows");
            send(2, 1, 0, "R10 flows");
            idle(4);
        end
        // R6: high flow overruns its length, then a clear releases the request
        idle(12);
        send(1, 5, 0, "R6 length");
        idle(10);
        send(1, 2, 1, "R7 clear");
        // R7: overrun in the same cycle as a clear keeps the request
        idle(10);
        send(1, 5, 4, "R7 set wins");
        idle(10);
        send(1, 1, 1, "R7 clear");
        // R6: high flow spacing overrun
        send(1, 1, 0, "R6 spacing");
        idle(2);
        chk(mode_req == 1, "R7 hold", mode_req, 1);
        mode_clr = 1;
        @(posedge clk); @(negedge clk);
        mode_clr = 0; exp_mode = 0;
        chk(mode_req == 0, "R7 clear", mode_req, 0);
        // R1: reconfigure flow 2 and observe the new limit
        cfg(2, 0, 1, 3, 0);
        send(2, 3, 0, "R1 rewrite");
        send(2, 4, 0, "R1 rewrite");
        idle(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule